// File: doc/BRIEF.md
# Split-Class Physical Register Free List

This block hands out free physical register tags to a register-renaming stage and takes them back when they retire. It keeps two first-in-first-out pools, one for integer tags and one for floating-point tags. Both pools draw from one physical index space: integer tags occupy the low range and floating-point tags begin directly above it, so the integer register count is also the floating-point base. A per-tag free bitmap runs beside the pools and checks every allocation and release. Misuse is latched into a sticky error vector.

Each class has an allocation stream. `*_alloc_valid` is high while the pool holds at least one tag, and `*_alloc_tag` shows the oldest free tag combinationally. A grant happens on a rising edge where valid and ready are both high, and the pool advances on that edge. The consumer must not raise ready while valid is low; doing so is treated as an illegal allocation, and no tag is granted. Releases are valid-only: the block has no back-pressure on them and takes them every cycle. There are three release inputs. Each class has its own release port, which pushes its tag into that class's pool without checking the range. A shared release port routes its tag by index.

With the defaults there are 8 integer tags, 4 of them architectural, and 8 floating-point tags, 4 of them architectural. The tag width is 5 bits, so out-of-range codes 16 to 31 exist.

Top module: `rename_free_list`

## Requirements
- R1: After reset, the integer pool holds tags NUM_LOG_INT..NUM_PHYS_INT-1 (4,5,6,7) in ascending order, and the floating-point pool holds NUM_PHYS_INT+NUM_LOG_FP..TOTAL-1 (12..15) in ascending order. Both counts are 4 and the error vector is 0.
- R2: Each pool is first-in-first-out. A grant always shows the oldest free tag of its class. If a class port and the shared port release into the same pool in one cycle, the class-port tag is queued first.
- R3: `*_alloc_valid` is high exactly when `*_free_cnt` is non-zero. The count rises by one for each accepted release and falls by one for each grant.
- R4: On the shared release port, a tag below NUM_PHYS_INT goes to the integer pool. A tag from NUM_PHYS_INT up to TOTAL-1 goes to the floating-point pool. A tag at or above TOTAL changes nothing.
- R5: A class release port enqueues its tag into its own pool whatever range the tag lies in. For example, tag 8 released on the floating-point port is later granted by the floating-point pool.
- R6: A grant and a release of the same class in one cycle both take effect, and the count stays the same. A tag released in a cycle is not granted in that cycle: a release into an empty pool while ready is high leaves the tag at the head, and the count becomes 1.
- R7: Raising ready on an empty pool grants nothing and sets error bit 0.
- R8: Releasing a tag whose free bit is already set sets error bit 2. This includes the same tag arriving on two release ports in one cycle. The tag is still queued if there is room.
- R9: Granting a tag whose free bit is clear sets error bit 1. This can happen to a tag queued twice after a double release.
- R10: Error bits stay set until reset, and reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_ready | input | 1 | Consumer takes the integer head tag this cycle |
| int_alloc_valid | output | 1 | Integer pool not empty |
| int_alloc_tag | output | TAG_W | Oldest free integer tag |
| fp_alloc_ready | input | 1 | Consumer takes the floating-point head tag this cycle |
| fp_alloc_valid | output | 1 | Floating-point pool not empty |
| fp_alloc_tag | output | TAG_W | Oldest free floating-point tag |
| int_rel_valid | input | 1 | Release into the integer pool, no range check |
| int_rel_tag | input | TAG_W | Tag released into the integer pool |
| fp_rel_valid | input | 1 | Release into the floating-point pool, no range check |
| fp_rel_tag | input | TAG_W | Tag released into the floating-point pool |
| any_rel_valid | input | 1 | Release routed by tag range |
| any_rel_tag | input | TAG_W | Tag on the shared release port |
| int_free_cnt | output | INT_CNT_W | Number of free integer tags |
| fp_free_cnt | output | FP_CNT_W | Number of free floating-point tags |
| err_code | output | 3 | Sticky: bit 0 empty grant, bit 1 double allocation, bit 2 double release |

## Verification
The checker watches several rules on every cycle. A ready on an empty pool must be followed by error bit 0. Error bits must never drop while out of reset. A lone grant must lower the count by exactly one. A same-cycle grant and release must leave the count unchanged. An out-of-range shared release must leave both counts alone, and counts must never exceed the pool depth. Other behaviour only shows up in the bench's scenarios because it needs a history to build on. That covers the oldest-first order of tags, which pool a routed or class-port tag reaches, the queuing order of two releases in one cycle, and a double allocation that appears only after a duplicate tag has worked its way to the head.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  localparam int ERR_W          = 3;
  localparam int ERR_EMPTY_BIT  = 0;
  localparam int ERR_DALLOC_BIT = 1;
  localparam int ERR_DREL_BIT   = 2;
  localparam int N_CLASS        = 2;
  localparam int N_REL          = 3;
endpackage

// File: rtl/rfl_tag_ring.sv
module rfl_tag_ring #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 5,
  parameter int BASE  = 0,
  parameter int SKIP  = 4,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int INIT_CNT = DEPTH - SKIP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push_a,
  input  logic [TAG_W-1:0] tag_a,
  input  logic             push_b,
  input  logic [TAG_W-1:0] tag_b,
  output logic [TAG_W-1:0] head,
  output logic [CNT_W-1:0] count
);
  logic [TAG_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_ptr_b;
  logic             do_pop, acc_a, acc_b;
  logic [CNT_W-1:0] avail;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop   = pop && (count != '0);
    avail    = CNT_W'(DEPTH) - count;
    acc_a    = push_a && (avail != '0);
    acc_b    = push_b && (avail > (acc_a ? CNT_W'(1) : CNT_W'(0)));
    wr_ptr_b = acc_a ? step(wr_ptr) : wr_ptr;
  end

  assign head = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slots[i] <= (i < INIT_CNT) ? TAG_W'(BASE + SKIP + i) : '0;
      rd_ptr <= '0;
      wr_ptr <= PTR_W'(INIT_CNT % DEPTH);
      count  <= CNT_W'(INIT_CNT);
    end else begin
      if (acc_a) slots[wr_ptr]   <= tag_a;
      if (acc_b) slots[wr_ptr_b] <= tag_b;
      if (do_pop) rd_ptr <= step(rd_ptr);
      if (acc_b)      wr_ptr <= step(wr_ptr_b);
      else if (acc_a) wr_ptr <= step(wr_ptr);
      count <= count + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/rfl_free_map.sv
module rfl_free_map
  import rfl_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int TAG_W    = 5,
  parameter int LO_A     = 4,
  parameter int HI_A     = 8,
  parameter int LO_B     = 12,
  localparam int SPAN    = 1 << TAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] alloc_v,
  input  logic [TAG_W-1:0]   alloc_tag [N_CLASS],
  input  logic [N_REL-1:0]   rel_v,
  input  logic [TAG_W-1:0]   rel_tag [N_REL],
  output logic [N_CLASS-1:0] alloc_bad,
  output logic               rel_bad
);
  logic [SPAN-1:0] free_q, free_d;

  function automatic logic in_map(input logic [TAG_W-1:0] t);
    return 32'(t) < NUM_TAGS;
  endfunction

  always_comb begin
    free_d  = free_q;
    rel_bad = 1'b0;
    for (int c = 0; c < N_CLASS; c++) begin
      alloc_bad[c] = alloc_v[c] && in_map(alloc_tag[c]) && !free_q[alloc_tag[c]];
      if (alloc_v[c] && in_map(alloc_tag[c])) free_d[alloc_tag[c]] = 1'b0;
    end
    for (int r = 0; r < N_REL; r++) begin
      if (rel_v[r] && in_map(rel_tag[r])) begin
        if (free_q[rel_tag[r]]) rel_bad = 1'b1;
        for (int e = 0; e < r; e++)
          if (rel_v[e] && rel_tag[e] == rel_tag[r]) rel_bad = 1'b1;
        free_d[rel_tag[r]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPAN; i++)
        free_q[i] <= ((i >= LO_A) && (i < HI_A)) || ((i >= LO_B) && (i < NUM_TAGS));
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
  import rfl_pkg::*;
#(
  parameter int NUM_LOG_INT  = 4,
  parameter int NUM_PHYS_INT = 8,
  parameter int NUM_LOG_FP   = 4,
  parameter int NUM_PHYS_FP  = 8,
  localparam int TOTAL     = NUM_PHYS_INT + NUM_PHYS_FP,
  localparam int TAG_W     = $clog2(TOTAL + 1),
  localparam int INT_CNT_W = $clog2(NUM_PHYS_INT + 1),
  localparam int FP_CNT_W  = $clog2(NUM_PHYS_FP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 int_alloc_ready,
  output logic                 int_alloc_valid,
  output logic [TAG_W-1:0]     int_alloc_tag,
  input  logic                 fp_alloc_ready,
  output logic                 fp_alloc_valid,
  output logic [TAG_W-1:0]     fp_alloc_tag,
  input  logic                 int_rel_valid,
  input  logic [TAG_W-1:0]     int_rel_tag,
  input  logic                 fp_rel_valid,
  input  logic [TAG_W-1:0]     fp_rel_tag,
  input  logic                 any_rel_valid,
  input  logic [TAG_W-1:0]     any_rel_tag,
  output logic [INT_CNT_W-1:0] int_free_cnt,
  output logic [FP_CNT_W-1:0]  fp_free_cnt,
  output logic [ERR_W-1:0]     err_code
);
  logic int_pop, fp_pop, any_to_int, any_to_fp;
  logic empty_hit, dalloc_hit, drel_hit;
  logic [N_CLASS-1:0] alloc_v, alloc_bad;
  logic [TAG_W-1:0]   alloc_tag [N_CLASS];
  logic [N_REL-1:0]   rel_v;
  logic [TAG_W-1:0]   rel_tag [N_REL];
  logic [ERR_W-1:0]   err_q;

  assign any_to_int = any_rel_valid && (any_rel_tag < TAG_W'(NUM_PHYS_INT));
  assign any_to_fp  = any_rel_valid && (any_rel_tag >= TAG_W'(NUM_PHYS_INT))
                                    && (any_rel_tag < TAG_W'(TOTAL));

  assign int_alloc_valid = (int_free_cnt != '0);
  assign fp_alloc_valid  = (fp_free_cnt != '0);
  assign int_pop = int_alloc_ready && int_alloc_valid;
  assign fp_pop  = fp_alloc_ready && fp_alloc_valid;

  rfl_tag_ring #(
    .DEPTH(NUM_PHYS_INT), .TAG_W(TAG_W), .BASE(0), .SKIP(NUM_LOG_INT)
  ) u_int_ring (
    .clk(clk), .rst_n(rst_n), .pop(int_pop),
    .push_a(int_rel_valid), .tag_a(int_rel_tag),
    .push_b(any_to_int), .tag_b(any_rel_tag),
    .head(int_alloc_tag), .count(int_free_cnt)
  );

  rfl_tag_ring #(
    .DEPTH(NUM_PHYS_FP), .TAG_W(TAG_W), .BASE(NUM_PHYS_INT), .SKIP(NUM_LOG_FP)
  ) u_fp_ring (
    .clk(clk), .rst_n(rst_n), .pop(fp_pop),
    .push_a(fp_rel_valid), .tag_a(fp_rel_tag),
    .push_b(any_to_fp), .tag_b(any_rel_tag),
    .head(fp_alloc_tag), .count(fp_free_cnt)
  );

  assign alloc_v      = {fp_pop, int_pop};
  assign alloc_tag[0] = int_alloc_tag;
  assign alloc_tag[1] = fp_alloc_tag;
  assign rel_v        = {any_to_int || any_to_fp, fp_rel_valid, int_rel_valid};
  assign rel_tag[0]   = int_rel_tag;
  assign rel_tag[1]   = fp_rel_tag;
  assign rel_tag[2]   = any_rel_tag;

  rfl_free_map #(
    .NUM_TAGS(TOTAL), .TAG_W(TAG_W),
    .LO_A(NUM_LOG_INT), .HI_A(NUM_PHYS_INT), .LO_B(NUM_PHYS_INT + NUM_LOG_FP)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .alloc_v(alloc_v), .alloc_tag(alloc_tag),
    .rel_v(rel_v), .rel_tag(rel_tag),
    .alloc_bad(alloc_bad), .rel_bad(rel_bad_w)
  );

  logic rel_bad_w;

  assign empty_hit  = (int_alloc_ready && !int_alloc_valid) || (fp_alloc_ready && !fp_alloc_valid);
  assign dalloc_hit = |alloc_bad;
  assign drel_hit   = rel_bad_w;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else begin
      err_q[ERR_EMPTY_BIT]  <= err_q[ERR_EMPTY_BIT]  | empty_hit;
      err_q[ERR_DALLOC_BIT] <= err_q[ERR_DALLOC_BIT] | dalloc_hit;
      err_q[ERR_DREL_BIT]   <= err_q[ERR_DREL_BIT]   | drel_hit;
    end
  end

  assign err_code = err_q;
endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
  parameter int NUM_PHYS_INT = 8,
  parameter int NUM_PHYS_FP  = 8,
  parameter int TAG_W        = 5,
  parameter int INT_CNT_W    = 4,
  parameter int FP_CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 int_alloc_ready,
  input logic                 int_alloc_valid,
  input logic                 fp_alloc_ready,
  input logic                 fp_alloc_valid,
  input logic                 int_rel_valid,
  input logic                 fp_rel_valid,
  input logic                 any_rel_valid,
  input logic [TAG_W-1:0]     any_rel_tag,
  input logic [INT_CNT_W-1:0] int_free_cnt,
  input logic [FP_CNT_W-1:0]  fp_free_cnt,
  input logic [2:0]           err_code
);
  localparam int TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  logic any_int, any_fp, any_out;
  assign any_int = any_rel_valid && (32'(any_rel_tag) < NUM_PHYS_INT);
  assign any_fp  = any_rel_valid && (32'(any_rel_tag) >= NUM_PHYS_INT) && (32'(any_rel_tag) < TOTAL);
  assign any_out = any_rel_valid && (32'(any_rel_tag) >= TOTAL);

  // R7: ready on an empty pool latches error bit 0
  a_r7_empty_grant_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_alloc_ready && !int_alloc_valid) || (fp_alloc_ready && !fp_alloc_valid)) |=> err_code[0]);

  // R10: error bits never clear while out of reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_code) & ~err_code) == 3'b000));

  // R3: a lone integer grant lowers the count by one
  a_r3_grant_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (int_alloc_ready && int_alloc_valid && !int_rel_valid && !any_int)
      |=> (int_free_cnt == $past(int_free_cnt) - 1'b1));

  // R6: grant plus single release in one cycle keeps the count
  a_r6_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_alloc_ready && fp_alloc_valid && (fp_rel_valid != any_fp)) |=> $stable(fp_free_cnt));

  // R4: an out-of-range shared release alone touches neither pool
  a_r4_out_of_range_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (any_out && !int_rel_valid && !fp_rel_valid && !int_alloc_ready && !fp_alloc_ready)
      |=> ($stable(int_free_cnt) && $stable(fp_free_cnt)));

  // R3: counts stay within pool depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(int_free_cnt) <= NUM_PHYS_INT) && (32'(fp_free_cnt) <= NUM_PHYS_FP));
endmodule

bind rename_free_list rfl_checker #(
  .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
  .TAG_W(TAG_W), .INT_CNT_W(INT_CNT_W), .FP_CNT_W(FP_CNT_W)
) u_rfl_checker (
  .clk(clk), .rst_n(rst_n),
  .int_alloc_ready(int_alloc_ready), .int_alloc_valid(int_alloc_valid),
  .fp_alloc_ready(fp_alloc_ready), .fp_alloc_valid(fp_alloc_valid),
  .int_rel_valid(int_rel_valid), .fp_rel_valid(fp_rel_valid),
  .any_rel_valid(any_rel_valid), .any_rel_tag(any_rel_tag),
  .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt),
  .err_code(err_code)
);

// File: tb/rename_free_list_bench.sv
module rename_free_list_bench;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_alloc_ready = 0, fp_alloc_ready = 0;
  logic int_rel_valid = 0, fp_rel_valid = 0, any_rel_valid = 0;
  logic [TW-1:0] int_rel_tag = '0, fp_rel_tag = '0, any_rel_tag = '0;
  logic int_alloc_valid, fp_alloc_valid;
  logic [TW-1:0] int_alloc_tag, fp_alloc_tag;
  logic [3:0] int_free_cnt, fp_free_cnt;
  logic [2:0] err_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rename_free_list u_rename_free_list (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_ready(int_alloc_ready), .int_alloc_valid(int_alloc_valid), .int_alloc_tag(int_alloc_tag),
    .fp_alloc_ready(fp_alloc_ready), .fp_alloc_valid(fp_alloc_valid), .fp_alloc_tag(fp_alloc_tag),
    .int_rel_valid(int_rel_valid), .int_rel_tag(int_rel_tag),
    .fp_rel_valid(fp_rel_valid), .fp_rel_tag(fp_rel_tag),
    .any_rel_valid(any_rel_valid), .any_rel_tag(any_rel_tag),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .err_code(err_code)
  );

  typedef struct packed {
    logic ir; logic fr;
    logic iv; logic [4:0] it;
    logic fv; logic [4:0] ft;
    logic gv; logic [4:0] gt;
    logic e_iv; logic [4:0] e_it;
    logic e_fv; logic [4:0] e_ft;
    logic [3:0] e_ic; logic [3:0] e_fc; logic [2:0] e_err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{0,0, 0,0,  0,0, 0,0,  1,4, 1,12, 4,4, 0},
    '{1,0, 0,0,  0,0, 0,0,  1,4, 1,12, 4,4, 0},
    '{1,1, 0,0,  0,0, 0,0,  1,5, 1,12, 3,4, 0},
    '{0,0, 0,0,  0,0, 1,4,  1,6, 1,13, 2,3, 0},
    '{0,0, 0,0,  0,0, 1,12, 1,6, 1,13, 3,3, 0},
    '{1,0, 1,5,  0,0, 0,0,  1,6, 1,13, 3,4, 0},
    '{0,0, 0,0,  0,0, 1,20, 1,7, 1,13, 3,4, 0},
    '{0,1, 0,0,  1,8, 0,0,  1,7, 1,13, 3,4, 0},
    '{0,0, 0,0,  0,0, 0,0,  1,7, 1,14, 3,4, 0},
    '{1,0, 0,0,  0,0, 0,0,  1,7, 1,14, 3,4, 0},
    '{1,0, 0,0,  0,0, 0,0,  1,4, 1,14, 2,4, 0},
    '{1,0, 0,0,  0,0, 0,0,  1,5, 1,14, 1,4, 0},
    '{0,1, 0,0,  0,0, 0,0,  0,0, 1,14, 0,4, 0},
    '{0,1, 0,0,  0,0, 0,0,  0,0, 1,15, 0,3, 0},
    '{0,1, 0,0,  0,0, 0,0,  0,0, 1,12, 0,2, 0},
    '{0,1, 0,0,  0,0, 0,0,  0,0, 1,8,  0,1, 0},
    '{0,0, 1,6,  0,0, 1,7,  0,0, 0,0,  0,0, 0},
    '{0,0, 0,0,  0,0, 0,0,  1,6, 0,0,  2,0, 0}
  };

  function automatic string req_of(int row);
    case (row)
      0:       return "R1";
      3, 4, 6: return "R4";
      5:       return "R6";
      7, 8:    return "R5";
      16:      return "R2";
      12, 17:  return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    int_alloc_ready = 0; fp_alloc_ready = 0;
    int_rel_valid = 0; fp_rel_valid = 0; any_rel_valid = 0;
    int_rel_tag = '0; fp_rel_tag = '0; any_rel_tag = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cyc(input logic ir, input logic fr, input logic iv, input int it,
                     input logic gv, input int gt);
    @(negedge clk);
    int_alloc_ready = ir; fp_alloc_ready = fr;
    int_rel_valid = iv; int_rel_tag = TW'(it);
    any_rel_valid = gv; any_rel_tag = TW'(gt);
    @(posedge clk);
    #1 idle_inputs();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      int_alloc_ready = TBL[i].ir; fp_alloc_ready = TBL[i].fr;
      int_rel_valid = TBL[i].iv; int_rel_tag = TBL[i].it;
      fp_rel_valid = TBL[i].fv; fp_rel_tag = TBL[i].ft;
      any_rel_valid = TBL[i].gv; any_rel_tag = TBL[i].gt;
      #1;
      checks++;
      if (int_alloc_valid !== TBL[i].e_iv || fp_alloc_valid !== TBL[i].e_fv ||
          (TBL[i].e_iv && int_alloc_tag !== TBL[i].e_it) ||
          (TBL[i].e_fv && fp_alloc_tag !== TBL[i].e_ft) ||
          int_free_cnt !== TBL[i].e_ic || fp_free_cnt !== TBL[i].e_fc ||
          err_code !== TBL[i].e_err) begin
        fails++;
        $display("FAIL %s row %0d: actual iv=%0d it=%0d fv=%0d ft=%0d ic=%0d fc=%0d err=%0d expected iv=%0d it=%0d fv=%0d ft=%0d ic=%0d fc=%0d err=%0d",
          req_of(i), i, int_alloc_valid, int_alloc_tag, fp_alloc_valid, fp_alloc_tag,
          int_free_cnt, fp_free_cnt, err_code, TBL[i].e_iv, TBL[i].e_it, TBL[i].e_fv,
          TBL[i].e_ft, TBL[i].e_ic, TBL[i].e_fc, TBL[i].e_err);
      end
      @(posedge clk);
    end
    @(negedge clk);
    idle_inputs();

    // R7 / R6: drain integer pool, then ready on empty with a release
    do_reset();
    repeat (4) cyc(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R7", "int count drained", int_free_cnt, 0);
    cyc(1, 0, 1, 4, 0, 0);
    @(negedge clk);
    check("R7", "err after empty grant", err_code, 3'b001);
    check("R6", "count after release on empty", int_free_cnt, 1);
    check("R6", "released tag held at head", int_alloc_tag, 4);

    // R10: sticky, then reset clears
    repeat (5) @(negedge clk);
    check("R10", "err still set", err_code, 3'b001);
    do_reset();
    @(negedge clk);
    check("R10", "err cleared by reset", err_code, 3'b000);
    check("R1", "int head after reset", int_alloc_tag, 4);

    // R8 then R9: double release of free tag 5, then duplicate reaches head
    cyc(0, 0, 1, 5, 0, 0);
    @(negedge clk);
    check("R8", "err after double release", err_code, 3'b100);
    check("R8", "duplicate still queued", int_free_cnt, 5);
    repeat (4) cyc(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9", "duplicate tag at head", int_alloc_tag, 5);
    cyc(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9", "err after double allocation", err_code, 3'b110);

    // R8: same tag on two ports in one cycle
    do_reset();
    cyc(0, 0, 1, 1, 1, 1);
    @(negedge clk);
    check("R8", "err after same-cycle duplicate", err_code, 3'b100);
    check("R8", "both copies queued", int_free_cnt, 6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule